// File: doc/BRIEF.md
# SCSI Target Selection Detector

This block sits beside a SCSI target's bus interface and decides whether the host is selecting one of the targets the device emulates. It resynchronizes the bus control lines (SEL, BSY, ATN, RST) and the eight data lines to the system clock. It evaluates a selection whenever SEL is seen asserted while BSY is released. On a match it latches a status byte holding the chosen ID.

Firmware then asks the block to drive BSY. The block waits a programmable delay, samples ATN, and uses that sample to decide whether the host is a SCSI-1 host that sends no IDENTIFY message. A separate path filters the bus reset line and only raises a sticky reset flag when RST is still asserted a programmable time after its leading edge.

All bus signals at the ports are logical, active high. The inversion of the physical active-low lines lies outside this block. Delays are given in nanoseconds and turned into cycle counts from the clock period parameter.

Top module: `scsi_sel_detect`

## Requirements
- R1: After reset, `sel_status`, `sel_seen`, `bsy_out`, `host_known`, `scsi1_mode` and `reset_flag` are all 0.
- R2: A selection is evaluated when the synchronized SEL becomes asserted while BSY is released, and also when BSY is released while SEL is asserted. A host that never asserts BSY is therefore still detected.
- R3: On a match, `sel_status` becomes {1'b1 (success, bit 7), 1'b1 (attention, bit 6), 3'b000, id[2:0]} and `sel_seen` is set. Both hold until `clr` or `bus_free` is pulsed.
- R4: Only table entries with `cfg_en[i]`=1 and a 4-bit ID below 8 take part. Entry i occupies `cfg_ids[4*i+3:4*i]`. The lowest-index matching entry whose ID bit is set on `bus_db` wins. With no match, the status is left unchanged.
- R5: While `bsy_out` is 1, selection events are ignored and `sel_status` keeps its value.
- R6: A `bsy_req` pulse while the status success bit is set and `bsy_out` is 0 sets `bsy_out`. `bsy_out` stays set until `bus_free`.
- R7: ATN_NS after BSY is driven, the synchronized ATN is sampled and `host_known` is set. If ATN is low, `scsi1_mode` is set and status bit 6 is cleared. If ATN is high, `scsi1_mode` stays 0 and bit 6 stays 1.
- R8: A rising RST starts a RST_NS window. `reset_flag` is set only if RST is still asserted when the window ends, so shorter pulses are ignored. The flag is sticky until `clr` or `bus_free`.
- R9: `clr` clears `sel_status`, `sel_seen` and `reset_flag` but leaves `bsy_out` and the host class. `bus_free` clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | SEL, logical asserted = 1 |
| bus_bsy | input | 1 | BSY as seen on the bus |
| bus_atn | input | 1 | ATN |
| bus_rst | input | 1 | Bus reset line |
| bus_db | input | 8 | Data lines, one bit per ID |
| cfg_en | input | N_TGT | Enable per target table entry |
| cfg_ids | input | 4*N_TGT | Target IDs, 4 bits per entry |
| bsy_req | input | 1 | Firmware request to drive BSY |
| clr | input | 1 | Clears latched status and reset flag |
| bus_free | input | 1 | Bus-free entry: clears everything |
| bsy_out | output | 1 | Drive BSY onto the bus |
| sel_status | output | 8 | Success, attention and ID |
| sel_seen | output | 1 | Sticky selected flag |
| host_known | output | 1 | Host class decided |
| scsi1_mode | output | 1 | Host classed as SCSI-1 |
| reset_flag | output | 1 | Filtered, sticky bus reset |

## Verification
The selection logic is tried with SEL rising while BSY stays low, and with BSY falling while SEL is already held. These two cases separate the two trigger paths. It is also tried with a data pattern that sets two configured bits, which shows that table order wins over bit order. Other patterns hit only a disabled entry or an entry whose ID is 8 or above, which shows that such entries are excluded. A reselection attempt made while BSY is driven shows the guard. ATN held high and ATN held low separate the two host classes. RST pulses shorter and longer than the window separate a glitch from a real reset.

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect #(
  parameter int N_TGT  = 4,
  parameter int CLK_NS = 20,
  parameter int ATN_NS = 100,
  parameter int RST_NS = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_bsy,
  input  logic               bus_atn,
  input  logic               bus_rst,
  input  logic [7:0]         bus_db,
  input  logic [N_TGT-1:0]   cfg_en,
  input  logic [4*N_TGT-1:0] cfg_ids,
  input  logic               bsy_req,
  input  logic               clr,
  input  logic               bus_free,
  output logic               bsy_out,
  output logic [7:0]         sel_status,
  output logic               sel_seen,
  output logic               host_known,
  output logic               scsi1_mode,
  output logic               reset_flag
);
  localparam int ATN_CYC = (ATN_NS + CLK_NS - 1) / CLK_NS;
  localparam int RST_CYC = (RST_NS + CLK_NS - 1) / CLK_NS;
  localparam int AW = $clog2(ATN_CYC + 1);
  localparam int RW = $clog2(RST_CYC + 1);

  logic [11:0] sync1, sync2;
  logic sel_d, bsy_d, rst_d;
  logic [AW-1:0] acnt;
  logic [RW-1:0] rcnt;

  wire [7:0] db_s  = sync2[11:4];
  wire       sel_s = sync2[3];
  wire       bsy_s = sync2[2];
  wire       atn_s = sync2[1];
  wire       rst_s = sync2[0];

  wire trig   = (sel_s & ~sel_d | ~bsy_s & bsy_d) & sel_s & ~bsy_s & ~bsy_out;
  wire stat_ok = sel_status[7];

  logic       hit;
  logic [2:0] hit_id;
  always_comb begin
    hit = 1'b0;
    hit_id = '0;
    for (int i = N_TGT - 1; i >= 0; i--)
      if (cfg_en[i] && !cfg_ids[4*i+3] && db_s[cfg_ids[4*i +: 3]]) begin
        hit = 1'b1;
        hit_id = cfg_ids[4*i +: 3];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0;
      sel_d <= 1'b0; bsy_d <= 1'b0; rst_d <= 1'b0;
    end else begin
      sync1 <= {bus_db, bus_sel, bus_bsy, bus_atn, bus_rst};
      sync2 <= sync1;
      sel_d <= sel_s; bsy_d <= bsy_s; rst_d <= rst_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bus_free) begin
      sel_status <= '0; sel_seen <= 1'b0; bsy_out <= 1'b0;
      host_known <= 1'b0; scsi1_mode <= 1'b0; acnt <= '0;
    end else begin
      if (clr) begin
        sel_status <= '0; sel_seen <= 1'b0;
      end else if (trig && hit) begin
        sel_status <= {2'b11, 3'b000, hit_id};
        sel_seen <= 1'b1;
      end
      if (bsy_req && stat_ok && !bsy_out) begin
        bsy_out <= 1'b1;
        acnt <= AW'(ATN_CYC);
      end else if (acnt != '0) begin
        acnt <= acnt - 1'b1;
        if (acnt == AW'(1)) begin
          host_known <= 1'b1;
          if (!atn_s) begin
            scsi1_mode <= 1'b1;
            if (!clr) sel_status[6] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= '0; reset_flag <= 1'b0;
    end else begin
      if (rcnt == '0) begin
        if (rst_s && !rst_d) rcnt <= RW'(RST_CYC);
      end else begin
        rcnt <= rcnt - 1'b1;
      end
      if (clr || bus_free) reset_flag <= 1'b0;
      else if (rcnt == RW'(1) && rst_s) reset_flag <= 1'b1;
    end
  end

  AST_BSY_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(stat_ok)); // R6
  AST_SEEN_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ok) |-> sel_seen); // R3
  AST_ID_HELD_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bsy_out) && !$past(clr) && !$past(bus_free) |-> $stable(sel_status[2:0])); // R5
  AST_CLASS_NEEDS_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_known) |-> bsy_out); // R7
  AST_RESET_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_flag) |-> $past(rst_s)); // R8
  AST_FREE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_free) |-> !bsy_out && !sel_seen); // R9
endmodule

// File: tb/scsi_sel_detect_tb_top.sv
`timescale 1ns/1ps
module scsi_sel_detect_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_bsy = 0, bus_atn = 0, bus_rst = 0;
  logic [7:0] bus_db = 0;
  logic [3:0] cfg_en = 4'b0111;
  logic [15:0] cfg_ids = {4'd6, 4'd9, 4'd2, 4'd5};
  logic bsy_req = 0, clr = 0, bus_free = 0;
  logic bsy_out, sel_seen, host_known, scsi1_mode, reset_flag;
  logic [7:0] sel_status;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  scsi_sel_detect dut_i (.clk, .rst_n, .bus_sel, .bus_bsy, .bus_atn, .bus_rst,
    .bus_db, .cfg_en, .cfg_ids, .bsy_req, .clr, .bus_free, .bsy_out,
    .sel_status, .sel_seen, .host_known, .scsi1_mode, .reset_flag);

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_free(); bus_free = 1; cyc(1); bus_free = 0; cyc(1); endtask
  task automatic pulse_req(); bsy_req = 1; cyc(1); bsy_req = 0; endtask

  task automatic idle_bus();
    bus_sel = 0; bus_bsy = 0; bus_db = 0; cyc(4); pulse_free();
  endtask

  task automatic t_reset();
    chk("R1 status", sel_status, 8'h00);
    chk("R1 flags", {bsy_out, sel_seen, host_known, scsi1_mode, reset_flag}, 8'h00);
  endtask

  task automatic t_sel_no_bsy();
    bus_db = 8'h04; bus_sel = 1; cyc(6);
    chk("R2 sel without bsy", sel_status, 8'hC2);
    chk("R3 seen", {7'd0, sel_seen}, 8'h01);
    bus_sel = 0; cyc(4);
    chk("R3 hold after sel drop", sel_status, 8'hC2);
    idle_bus();
  endtask

  task automatic t_sel_bsy_first();
    bus_bsy = 1; bus_sel = 1; bus_db = 8'h20; cyc(6);
    chk("R2 no eval while bsy", sel_status, 8'h00);
    bus_bsy = 0; cyc(6);
    chk("R2 bsy release trigger", sel_status, 8'hC5);
    idle_bus();
  endtask

  task automatic t_priority();
    bus_db = 8'h24; bus_sel = 1; cyc(6);
    chk("R4 table order wins", sel_status, 8'hC5);
    idle_bus();
  endtask

  task automatic t_no_match();
    bus_db = 8'h42; bus_sel = 1; cyc(6);
    chk("R4 id>=8 and disabled excluded", sel_status, 8'h00);
    chk("R4 not seen", {7'd0, sel_seen}, 8'h00);
    idle_bus();
  endtask

  task automatic t_scsi2_and_guard();
    bus_atn = 1; bus_db = 8'h20; bus_sel = 1; cyc(6);
    pulse_req(); cyc(1);
    chk("R6 bsy driven", {7'd0, bsy_out}, 8'h01);
    cyc(10);
    chk("R7 scsi2 class", {6'd0, host_known, scsi1_mode}, 8'h02);
    chk("R7 atn bit kept", sel_status, 8'hC5);
    bus_sel = 0; cyc(4); bus_db = 8'h04; bus_sel = 1; cyc(6);
    chk("R5 ignored while driving", sel_status, 8'hC5);
    clr = 1; cyc(1); clr = 0; cyc(1);
    chk("R9 clr status", sel_status, 8'h00);
    chk("R9 clr keeps bsy/class", {5'd0, bsy_out, host_known, sel_seen}, 8'h06);
    bus_atn = 0;
    idle_bus();
    chk("R9 bus_free clears", {bsy_out, sel_seen, host_known, scsi1_mode, sel_status[7], 3'd0}, 8'h00);
  endtask

  task automatic t_req_without_sel();
    pulse_req(); cyc(3);
    chk("R6 req ignored without match", {7'd0, bsy_out}, 8'h00);
  endtask

  task automatic t_scsi1();
    bus_atn = 0; bus_db = 8'h04; bus_sel = 1; cyc(6);
    pulse_req(); cyc(12);
    chk("R7 scsi1 class", {6'd0, host_known, scsi1_mode}, 8'h03);
    chk("R7 atn bit cleared", sel_status, 8'h82);
    idle_bus();
  endtask

  task automatic t_rst();
    bus_rst = 1; cyc(5); bus_rst = 0; cyc(40);
    chk("R8 glitch ignored", {7'd0, reset_flag}, 8'h00);
    bus_rst = 1; cyc(40);
    chk("R8 real reset", {7'd0, reset_flag}, 8'h01);
    bus_rst = 0; cyc(10);
    chk("R8 sticky", {7'd0, reset_flag}, 8'h01);
    clr = 1; cyc(1); clr = 0; cyc(1);
    chk("R9 clr reset flag", {7'd0, reset_flag}, 8'h00);
  endtask

  initial begin
    cyc(4); rst_n = 1; cyc(2);
    t_reset();
    t_sel_no_bsy();
    t_sel_bsy_first();
    t_priority();
    t_no_match();
    t_req_without_sel();
    t_scsi2_and_guard();
    t_scsi1();
    t_rst();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule